// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block is the transmit sequencer a LIN bus master uses to put a frame header on the wire. Software programs the header content and then pulses a start input. The block drives a dominant (low) break, a recessive (high) delimiter, a framed sync byte of value 0x55 and a framed protected identifier byte. A two-bit select code decides how much of that sequence goes out.

Bit timing comes from a sample tick running at a fixed oversampling ratio (`OVS` ticks per bit). Each bit lasts exactly `OVS` ticks. The identifier can go out exactly as programmed, or with its two top bits replaced by parity that the hardware computes. While the header is on the wire, the block compares the bus read-back against its own driven level at the middle of every bit. Any difference sets a sticky error flag.

Top module: `lin_hdr_tx`

## Requirements
- R1: After an accepted start, `tx_o` is held low for `brk_len_i + 1` bit times (the break).
- R2: After the break, `tx_o` is held high for `dlm_len_i + 1` bit times (the delimiter). This gives 1 to 4 bit times.
- R3: The select code picks the header content:
  - Code 0 sends break and delimiter only.
  - Code 1 adds the sync byte.
  - Code 2 adds the sync byte and the identifier byte.
  - A start with code 3 is ignored and the block stays idle.
  - A start that arrives while busy is ignored.
- R4: The sync field is the byte 0x55, sent least significant bit first. It is framed by one start bit (0) before it and one stop bit (1) after it.
- R5: The identifier byte is sent least significant bit first, with the same start and stop framing, beginning with `pid_i[0]`. With `par_en_i` = 0, all 8 bits go out exactly as programmed.
- R6: With `par_en_i` = 1, bit 6 is replaced by `id0^id1^id2^id4` and bit 7 by `~(id1^id3^id4^id5)`. Bits 5..0 are sent as programmed.
- R7: `busy_o` rises in the cycle after an accepted start. It falls in the same cycle in which the last bit of the selected header ends.
- R8: While busy, the block samples at tick number `OVS/2` of each bit. If `rx_i` differs from `tx_o` there, `berr_o` is set and stays set. A pulse on `berr_clr_i` clears it, and a new error in the same cycle wins over the clear.
- R9: After reset, `tx_o` = 1, `busy_o` = 0 and `berr_o` = 0. While idle, `tx_o` stays high.
- R10: Each bit lasts exactly `OVS` sample ticks. Clock cycles without a tick do not advance the header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_tick_i | input | 1 | One-cycle pulse, `OVS` per bit time |
| start_i | input | 1 | Start-header pulse |
| hdr_sel_i | input | 2 | Header content select (0 to 2 valid) |
| brk_len_i | input | BRK_W | Break length minus one, in bits |
| dlm_len_i | input | 2 | Delimiter length minus one, in bits |
| pid_i | input | 8 | Identifier byte |
| par_en_i | input | 1 | Hardware identifier parity enable |
| rx_i | input | 1 | Bus read-back |
| berr_clr_i | input | 1 | Clear pulse for the bit-error flag |
| tx_o | output | 1 | Bus transmit line |
| busy_o | output | 1 | Header in progress; clears itself at the end |
| berr_o | output | 1 | Sticky bit-error flag |

## Verification
The assertions take several things for granted about the inputs:
- The configuration inputs are captured only at the start pulse, so their later values are not relied on.
- `samp_tick_i` is a single-cycle pulse.
- `rx_i` may take any value at any time.

The stimulus changes all inputs half a cycle away from the active edge. It runs the tick every cycle in some headers and every third cycle in others. It forces read-back mismatches through an explicit inject term on the loop-back path, so that every error the bench expects comes from a known window.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DLM,
    ST_SYN,
    ST_PID
  } hdr_st_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [1:0] SEL_BRK   = 2'd0;
  localparam logic [1:0] SEL_SYN   = 2'd1;
  localparam logic [1:0] SEL_PID   = 2'd2;
  localparam logic [1:0] SEL_RSV   = 2'd3;

  // framed byte: start(0), data lsb first, stop(1)
  localparam int unsigned FRAME_LAST = 9;

  function automatic logic [7:0] pid_add_parity(input logic [7:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id[5:0]};
  endfunction

endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic mid_o,
  output logic end_o
);
  localparam int unsigned SUB_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2);

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sub_q <= '0;
    else if (clr_i)              sub_q <= '0;
    else if (run_i && tick_i) begin
      if (sub_q == SUB_LAST)     sub_q <= '0;
      else                       sub_q <= sub_q + 1'b1;
    end
  end

  assign mid_o = run_i && tick_i && (sub_q == SUB_MID);
  assign end_o = run_i && tick_i && (sub_q == SUB_LAST);

  // R10: without a tick the count holds
  assert_sub_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(sub_q));

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int unsigned BRK_W = 4,
  parameter int unsigned DLM_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       sel_i,
  input  logic [BRK_W-1:0] brk_i,
  input  logic [DLM_W-1:0] dlm_i,
  input  logic [7:0]       pid_i,
  input  logic             par_en_i,
  input  logic             bit_end_i,
  output logic             go_o,
  output logic             busy_o,
  output logic             tx_o
);
  localparam int unsigned CNT_W = (BRK_W > 4) ? BRK_W : 4;
  localparam logic [CNT_W-1:0] CNT_FLAST = CNT_W'(FRAME_LAST);

  hdr_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sel_q;
  logic [BRK_W-1:0] brk_q;
  logic [DLM_W-1:0] dlm_q;
  logic [7:0]       pid_q;
  logic [9:0]       frame;

  assign go_o = (st_q == ST_IDLE) && start_i && (sel_i != SEL_RSV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= SEL_BRK;
      brk_q <= '0;
      dlm_q <= '0;
      pid_q <= '0;
    end else if (go_o) begin
      st_q  <= ST_BRK;
      cnt_q <= '0;
      sel_q <= sel_i;
      brk_q <= brk_i;
      dlm_q <= dlm_i;
      pid_q <= par_en_i ? pid_add_parity(pid_i) : pid_i;
    end else if (bit_end_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        ST_BRK: if (cnt_q == CNT_W'(brk_q)) begin
          st_q  <= ST_DLM;
          cnt_q <= '0;
        end
        ST_DLM: if (cnt_q == CNT_W'(dlm_q)) begin
          st_q  <= (sel_q == SEL_BRK) ? ST_IDLE : ST_SYN;
          cnt_q <= '0;
        end
        ST_SYN: if (cnt_q == CNT_FLAST) begin
          st_q  <= (sel_q == SEL_SYN) ? ST_IDLE : ST_PID;
          cnt_q <= '0;
        end
        ST_PID: if (cnt_q == CNT_FLAST) begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  always_comb begin
    frame = (st_q == ST_SYN) ? {1'b1, SYNC_BYTE, 1'b0} : {1'b1, pid_q, 1'b0};
    unique case (st_q)
      ST_BRK:          tx_o = 1'b0;
      ST_SYN, ST_PID:  tx_o = frame[cnt_q[3:0]];
      default:         tx_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  // R3: reserved code never starts a header
  assert_rsv_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && sel_i == SEL_RSV) |=> !busy_o);

  // R7: header only ends on a bit boundary
  assert_end_on_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_end_i) |=> busy_o);

  // R10: line only moves at a bit boundary
  assert_line_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_end_i) |=> $stable(tx_o));

  // R9: idle line is recessive
  assert_idle_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

endmodule

// File: rtl/lin_bit_mon.sv
module lin_bit_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mid_i,
  input  logic busy_i,
  input  logic tx_i,
  input  logic rx_i,
  input  logic clr_i,
  output logic berr_o
);
  logic hit;
  logic berr_q;

  assign hit = busy_i && mid_i && (rx_i != tx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    berr_q <= 1'b0;
    else if (hit)   berr_q <= 1'b1;
    else if (clr_i) berr_q <= 1'b0;
  end

  assign berr_o = berr_q;

  // R8: flag is sticky until cleared
  assert_berr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (berr_q && !clr_i) |=> berr_q);

  // R8: flag only rises through a mid-bit sample
  assert_berr_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(berr_q) |-> $past(mid_i && busy_i));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int unsigned OVS   = 16,
  parameter int unsigned BRK_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_tick_i,
  input  logic             start_i,
  input  logic [1:0]       hdr_sel_i,
  input  logic [BRK_W-1:0] brk_len_i,
  input  logic [1:0]       dlm_len_i,
  input  logic [7:0]       pid_i,
  input  logic             par_en_i,
  input  logic             rx_i,
  input  logic             berr_clr_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             berr_o
);
  logic go, mid, bit_end, busy, tx;

  lin_bit_timer #(.OVS(OVS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go),
    .run_i  (busy),
    .tick_i (samp_tick_i),
    .mid_o  (mid),
    .end_o  (bit_end)
  );

  lin_hdr_seq #(.BRK_W(BRK_W), .DLM_W(2)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sel_i     (hdr_sel_i),
    .brk_i     (brk_len_i),
    .dlm_i     (dlm_len_i),
    .pid_i     (pid_i),
    .par_en_i  (par_en_i),
    .bit_end_i (bit_end),
    .go_o      (go),
    .busy_o    (busy),
    .tx_o      (tx)
  );

  lin_bit_mon u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mid_i  (mid),
    .busy_i (busy),
    .tx_i   (tx),
    .rx_i   (rx_i),
    .clr_i  (berr_clr_i),
    .berr_o (berr_o)
  );

  assign tx_o   = tx;
  assign busy_o = busy;

  // R7: an accepted start raises busy next cycle
  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i && hdr_sel_i != 2'd3) |=> busy);

endmodule

// File: tb/lin_hdr_tx_tb_top.sv
`timescale 1ns/1ps
module lin_hdr_tx_tb_top;
  localparam int OVS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, par_en = 1'b0, clr = 1'b0, inj = 1'b0;
  logic [1:0] sel = '0, dlm = '0;
  logic [3:0] brk = '0;
  logic [7:0] pid = '0;
  logic rx, tx, busy, berr;
  int   tick_div = 1;
  int   cyc = 0;
  int   n_run = 0, n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  assign rx = tx ^ inj;

  lin_hdr_tx #(.OVS(OVS), .BRK_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .samp_tick_i(tick), .start_i(start),
    .hdr_sel_i(sel), .brk_len_i(brk), .dlm_len_i(dlm), .pid_i(pid),
    .par_en_i(par_en), .rx_i(rx), .berr_clr_i(clr),
    .tx_o(tx), .busy_o(busy), .berr_o(berr)
  );

  // behavioural reference
  bit    m_q[$];
  string m_tag[$];
  bit    m_busy = 0, m_berr = 0;
  int    m_sub = 0;

  function automatic void push_frame(input logic [7:0] b, input bit pe, input bit is_id);
    m_q.push_back(1'b0); m_tag.push_back("R4 R5");
    for (int i = 0; i < 8; i++) begin
      m_q.push_back(b[i]);
      m_tag.push_back(!is_id ? "R4" : (pe && i >= 6) ? "R6" : "R5");
    end
    m_q.push_back(1'b1); m_tag.push_back("R4 R5");
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        if (tick && m_sub == OVS/2 && inj) m_berr = 1;
        else if (clr) m_berr = 0;
        if (tick) begin
          if (m_sub == OVS-1) begin
            m_sub = 0;
            void'(m_q.pop_front()); void'(m_tag.pop_front());
            if (m_q.size() == 0) m_busy = 0;
          end else m_sub++;
        end
      end else begin
        if (clr) m_berr = 0;
        if (start && sel != 2'd3) begin
          logic [7:0] idb;
          idb = pid;
          if (par_en) begin
            idb[6] = pid[0]^pid[1]^pid[2]^pid[4];
            idb[7] = ~(pid[1]^pid[3]^pid[4]^pid[5]);
          end
          for (int i = 0; i <= brk; i++) begin m_q.push_back(1'b0); m_tag.push_back("R1 R10"); end
          for (int i = 0; i <= dlm; i++) begin m_q.push_back(1'b1); m_tag.push_back("R2 R3"); end
          if (sel >= 2'd1) push_frame(8'h55, 1'b0, 1'b0);
          if (sel == 2'd2) push_frame(idb, par_en, 1'b1);
          m_busy = 1; m_sub = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  // compare every cycle away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(m_busy ? m_tag[0] : "R9", tx, m_busy ? m_q[0] : 1'b1);
      chk("R7", busy, m_busy);
      chk("R8", berr, m_berr);
    end
    tick <= (tick_div <= 1) ? 1'b1 : (cyc % tick_div == 0);
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] s, input logic [3:0] b, input logic [1:0] d,
                        input logic [7:0] p, input logic pe);
    @(negedge clk);
    sel = s; brk = b; dlm = d; pid = p; par_en = pe;
    pulse_start();
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", tx, 1'b1); chk("R9", busy, 1'b0); chk("R9", berr, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    header(2'd2, 4'd12, 2'd0, 8'h3A, 1'b1);  // full header, hw parity
    header(2'd0, 4'd0,  2'd3, 8'h00, 1'b0);  // break only
    tick_div = 3;
    header(2'd1, 4'd15, 2'd1, 8'hFF, 1'b1);  // break + sync, sparse ticks (R10)
    tick_div = 1;
    header(2'd2, 4'd3,  2'd2, 8'hC5, 1'b0);  // raw identifier
    header(2'd2, 4'd1,  2'd1, 8'h17, 1'b1);

    // R3 reserved select ignored
    @(negedge clk); sel = 2'd3;
    pulse_start();
    repeat (4) @(negedge clk);
    chk("R3", busy, 1'b0); chk("R3", tx, 1'b1);

    // R3 start while busy ignored, R8 injected mismatch
    @(negedge clk); sel = 2'd2; brk = 4'd2; dlm = 2'd0; pid = 8'h9C; par_en = 1'b0;
    pulse_start();
    repeat (OVS*4) @(negedge clk);
    sel = 2'd0; brk = 4'd9;
    pulse_start();
    inj = 1'b1;
    repeat (OVS) @(negedge clk);
    inj = 1'b0;
    chk("R8", berr, 1'b1);
    wait_idle();
    chk("R8", berr, 1'b1);   // sticky after header
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    chk("R8", berr, 1'b0);

    // R8 mismatch ignored while idle
    inj = 1'b1; tick_div = 1;
    repeat (OVS*2) @(negedge clk);
    inj = 1'b0;
    chk("R8", berr, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule